// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Transfer Engine

This block moves data between peripherals and memory without the data ever passing through it. Each of four channels has its own request line from a peripheral. When an armed channel asks for service, the engine requests the system bus from the host with a hold request. Once it receives hold acknowledge, it drives the memory address and the read/write strobes for both sides of the transfer. It also raises that channel's acknowledge, and the peripheral and the memory exchange the data directly on the shared bus.

Software loads each channel with a single configuration write. The write sets the start address, the transfer count minus one, the transfer mode, the auto-reload option and the direction, and it arms the channel. Each transfer advances a 16-bit address and lowers the count. The transfer made at count zero is the final one, and a shared end-of-process output pulses during it. After that final transfer the channel either disarms itself and flags completion, or it reloads its programmed values and stays armed. Three modes set how long one channel keeps the bus:
- single: one transfer per bus tenure;
- block: the whole buffer in one go;
- demand: as long as the peripheral keeps asking.

Top module: `dma_flyby_engine`

## Requirements
- R1: At most one bit of `dack` is high at any time. When several eligible channels request together, the lowest-numbered one is served first. A channel that holds the bus is never pre-empted: arbitration happens only while the engine is idle.
- R2: A channel is eligible only when its `dreq` bit is high and it is armed. The engine first raises `hold_req`. It drives the bus (`bus_oe` high) only after `hold_ack` has been seen high, and it waits with `hold_req` high for as long as `hold_ack` stays low.
- R3: While `bus_oe` is high, `bus_addr` shows the active channel's current address and exactly one `dack` bit is high. With direction bit 1 (peripheral to memory), `io_rd` and `mem_wr` are high. With direction bit 0 (memory to peripheral), `mem_rd` and `io_wr` are high. With `bus_oe` low, all strobes, `dack` and `bus_addr` are zero.
- R4: A transfer completes on a clock edge where `ready` is high. While `ready` is low, the address, strobes and acknowledge hold, and neither the address nor the count moves.
- R5: Each completed transfer raises the channel address by one and lowers the count by one. A programmed count C yields exactly C+1 transfers.
- R6: `eop` is high only in the cycle that completes a channel's transfer at count zero.
- R7: Without auto-reload, the final transfer disarms the channel and sets its `tc_flags` bit. Later requests on that channel are ignored until a configuration write re-arms it, and that write also clears the flag.
- R8: With auto-reload (`cfg_auto`=1), the final transfer restores the programmed address and count. The channel stays armed, its flag stays clear, and the bus is released.
- R9: Block mode (`cfg_mode`=1): once the transfer starts, it runs to the final transfer in one tenure, whatever `dreq` does.
- R10: Demand mode (`cfg_mode`=2): transfers continue while `dreq` is high at each completing edge. If `dreq` is low at a completing edge, the engine releases the bus after that transfer. A later request resumes from the saved address and count.
- R11: Single mode (`cfg_mode`=0, and the unused code 3): exactly one transfer per tenure. The bus is then released and the engine re-arbitrates, even if `dreq` stays high.
- R12: On release, `bus_oe` falls first and `hold_req` falls one cycle later. `hold_req` then stays low for at least one cycle.
- R13: The address wraps from 0xFFFF to 0x0000.
- R14: After reset, all channels are disarmed, all flags are clear and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe; loads and arms channel `cfg_ch` |
| cfg_ch | input | 2 | Channel selected by the configuration write |
| cfg_addr | input | 16 | Start address |
| cfg_count | input | 16 | Transfer count minus one |
| cfg_mode | input | 2 | 0 single, 1 block, 2 demand, 3 single |
| cfg_auto | input | 1 | Reload at terminal count |
| cfg_to_mem | input | 1 | 1: peripheral to memory, 0: memory to peripheral |
| dreq | input | 4 | Peripheral request lines |
| hold_ack | input | 1 | Host grants the bus |
| ready | input | 1 | Low stretches the current transfer |
| hold_req | output | 1 | Bus request to the host |
| bus_oe | output | 1 | Engine is driving address and strobes |
| bus_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| dack | output | 4 | Per-channel acknowledge |
| eop | output | 1 | End of process, final transfer of a channel |
| tc_flags | output | 4 | Per-channel terminal-count flags |

## Verification
The assertions watch every cycle for the invariants:
- a single acknowledge and paired strobes;
- no bus drive before hold acknowledge;
- frozen state while `ready` is low;
- an address step between back-to-back transfers and the wrap past 0xFFFF;
- disarm or reload at the final transfer;
- the release order of `bus_oe` and `hold_req`;
- the per-mode decision to keep or drop the bus.

Other behaviours only the bench's scenarios can show, because they need a reference model of every channel's address and count. These are the exact number of transfers per programmed count, the demand pause and resume with no lost or repeated address, fixed priority between simultaneous requests, requests that a finished channel ignores, and the reload across repeated auto-reload buffers.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_BLOCK  = 2'd1,
    MODE_DEMAND = 2'd2,
    MODE_SPARE  = 2'd3
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_XFER = 2'd2,
    ST_REL  = 2'd3
  } eng_state_e;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_cnt,
  input  xfer_mode_e    ld_mode,
  input  logic          ld_auto,
  input  logic          ld_to_mem,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output xfer_mode_e    mode,
  output logic          to_mem,
  output logic          armed,
  output logic          tc_flag,
  output logic          at_tc
);

  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;
  logic [CW-1:0] cur_cnt;
  logic          auto_en;

  function automatic logic [AW-1:0] addr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign at_tc = (cur_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
      mode      <= MODE_SINGLE;
      auto_en   <= 1'b0;
      to_mem    <= 1'b0;
      armed     <= 1'b0;
      tc_flag   <= 1'b0;
    end else if (load) begin
      base_addr <= ld_addr;
      base_cnt  <= ld_cnt;
      cur_addr  <= ld_addr;
      cur_cnt   <= ld_cnt;
      mode      <= ld_mode;
      auto_en   <= ld_auto;
      to_mem    <= ld_to_mem;
      armed     <= 1'b1;
      tc_flag   <= 1'b0;
    end else if (step) begin
      if (at_tc && auto_en) begin
        cur_addr <= base_addr;
        cur_cnt  <= base_cnt;
      end else begin
        cur_addr <= addr_next(cur_addr);
        cur_cnt  <= cnt_next(cur_cnt);
        if (at_tc) begin
          armed   <= 1'b0;
          tc_flag <= 1'b1;
        end
      end
    end
  end

  AST_TC_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_tc && !auto_en && !load) |=> (!armed && tc_flag)); // R7
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_tc && auto_en && !load) |=> (cur_addr == base_addr && cur_cnt == base_cnt && armed && !tc_flag)); // R8
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_tc && !load && cur_addr == '1) |=> (cur_addr == '0)); // R13

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req,
  output logic           grant_valid,
  output logic [CHW-1:0] grant_idx
);

  function automatic logic [CHW-1:0] lowest_set(input logic [NCH-1:0] v);
    logic [CHW-1:0] idx;
    idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (v[i]) idx = CHW'(i);
    end
    return idx;
  endfunction

  assign grant_valid = |req;
  assign grant_idx   = lowest_set(req);

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pick_valid,
  input  logic [CHW-1:0] pick_idx,
  input  logic           hold_ack,
  input  logic           ready,
  input  xfer_mode_e     act_mode,
  input  logic           act_at_tc,
  input  logic           act_req,
  output logic [CHW-1:0] act_ch,
  output logic           hold_req,
  output logic           bus_oe,
  output logic           step
);

  eng_state_e state;

  function automatic logic keep_bus(input xfer_mode_e m, input logic tc, input logic rq);
    case (m)
      MODE_BLOCK:  return !tc;
      MODE_DEMAND: return !tc && rq;
      default:     return 1'b0;
    endcase
  endfunction

  assign hold_req = (state != ST_IDLE);
  assign bus_oe   = (state == ST_XFER);
  assign step     = bus_oe && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      act_ch <= '0;
    end else begin
      case (state)
        ST_IDLE: if (pick_valid) begin
          act_ch <= pick_idx;
          state  <= ST_HOLD;
        end
        ST_HOLD: if (hold_ack) state <= ST_XFER;
        ST_XFER: if (ready) state <= keep_bus(act_mode, act_at_tc, act_req) ? ST_XFER : ST_REL;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUS_AFTER_HLDA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> $past(hold_ack)); // R2
  AST_READY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && !ready) |=> (bus_oe && $stable(act_ch))); // R4
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && $past(hold_req)) |-> $stable(act_ch)); // R1
  AST_BLOCK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_mode == MODE_BLOCK && !act_at_tc) |=> bus_oe); // R9
  AST_SINGLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (act_mode == MODE_SINGLE || act_mode == MODE_SPARE)) |=> !bus_oe); // R11
  AST_DEMAND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && act_mode == MODE_DEMAND && !act_req) |=> !bus_oe); // R10

endmodule

// File: rtl/dma_flyby_engine.sv
module dma_flyby_engine
  import dma_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [CW-1:0]  cfg_count,
  input  logic [1:0]     cfg_mode,
  input  logic           cfg_auto,
  input  logic           cfg_to_mem,
  input  logic [NCH-1:0] dreq,
  input  logic           hold_ack,
  input  logic           ready,
  output logic           hold_req,
  output logic           bus_oe,
  output logic [AW-1:0]  bus_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic [NCH-1:0] dack,
  output logic           eop,
  output logic [NCH-1:0] tc_flags
);

  logic [NCH-1:0] armed_v, attc_v, tomem_v, eligible;
  logic [AW-1:0]  addr_v [NCH];
  xfer_mode_e     mode_v [NCH];
  logic           pick_valid, step;
  logic [CHW-1:0] pick_idx, act_ch;
  logic           act_to_mem;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_we && cfg_ch == CHW'(g)),
      .ld_addr   (cfg_addr),
      .ld_cnt    (cfg_count),
      .ld_mode   (xfer_mode_e'(cfg_mode)),
      .ld_auto   (cfg_auto),
      .ld_to_mem (cfg_to_mem),
      .step      (step && act_ch == CHW'(g)),
      .cur_addr  (addr_v[g]),
      .mode      (mode_v[g]),
      .to_mem    (tomem_v[g]),
      .armed     (armed_v[g]),
      .tc_flag   (tc_flags[g]),
      .at_tc     (attc_v[g])
    );
    assign dack[g] = bus_oe && (act_ch == CHW'(g));
  end

  assign eligible = dreq & armed_v;

  dma_prio_arb #(.NCH(NCH)) u_arb (
    .req         (eligible),
    .grant_valid (pick_valid),
    .grant_idx   (pick_idx)
  );

  dma_xfer_seq #(.NCH(NCH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx),
    .hold_ack   (hold_ack),
    .ready      (ready),
    .act_mode   (mode_v[act_ch]),
    .act_at_tc  (attc_v[act_ch]),
    .act_req    (dreq[act_ch]),
    .act_ch     (act_ch),
    .hold_req   (hold_req),
    .bus_oe     (bus_oe),
    .step       (step)
  );

  assign act_to_mem = tomem_v[act_ch];
  assign bus_addr   = bus_oe ? addr_v[act_ch] : '0;
  assign mem_wr     = bus_oe &&  act_to_mem;
  assign io_rd      = bus_oe &&  act_to_mem;
  assign mem_rd     = bus_oe && !act_to_mem;
  assign io_wr      = bus_oe && !act_to_mem;
  assign eop        = step && attc_v[act_ch];

  AST_ONE_DACK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack)); // R1
  AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($countones(dack) == 1 && mem_wr == io_rd && mem_rd == io_wr && mem_wr != mem_rd)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && ready && !eop) |=> (!bus_oe || bus_addr == $past(bus_addr) + AW'(1))); // R5
  AST_EOP_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    eop |-> (bus_oe && ready)); // R6
  AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_req) |-> $past(!bus_oe)); // R12

endmodule

// File: tb/tb_dma_flyby_engine.sv
`timescale 1ns/1ps
module tb_dma_flyby_engine;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_count = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_auto = 1'b0;
  logic        cfg_to_mem = 1'b0;
  logic [3:0]  dreq = '0;
  logic        hold_ack;
  logic        ready = 1'b1;
  logic        hold_req, bus_oe, mem_rd, mem_wr, io_rd, io_wr, eop;
  logic [15:0] bus_addr;
  logic [3:0]  dack, tc_flags;
  logic        host_en = 1'b1;

  always #2 clk = ~clk;

  dma_flyby_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr),
    .cfg_count(cfg_count), .cfg_mode(cfg_mode), .cfg_auto(cfg_auto), .cfg_to_mem(cfg_to_mem),
    .dreq(dreq), .hold_ack(hold_ack), .ready(ready), .hold_req(hold_req), .bus_oe(bus_oe),
    .bus_addr(bus_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
    .dack(dack), .eop(eop), .tc_flags(tc_flags)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req && host_en;

  // reference model, written only by the monitor
  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [15:0] m_badr [4];
  logic [15:0] m_bcnt [4];
  bit          m_auto [4];
  bit          m_arm  [4];
  bit          m_tom  [4];
  int          m_mode [4];
  int          nx     [4];
  int oe_cycles = 0, stall_cycles = 0, eop_cnt = 0, tenure = 0;
  bit saw_wrap = 0, prev_hold = 0, prev_oe = 0;
  logic [15:0] last_addr = '0;
  int m_checks = 0, m_fails = 0;
  int d_checks = 0, d_fails = 0;
  int cyc = 0;

  initial for (int i = 0; i < 4; i++) begin
    m_addr[i] = '0; m_cnt[i] = '0; m_badr[i] = '0; m_bcnt[i] = '0;
    m_auto[i] = 0; m_arm[i] = 0; m_tom[i] = 0; m_mode[i] = 0; nx[i] = 0;
  end

  function automatic bit is_single(input int m);
    return (m == 0) || (m == 3);
  endfunction

  function automatic logic [15:0] wrap_inc(input logic [15:0] a);
    return 16'((32'(a) + 1) % 65536);
  endfunction

  task automatic mchk(input bit ok, input string req, input string what, input int act, input int exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic dchk(input bit ok, input string req, input string what, input int act, input int exp);
    d_checks++;
    if (!ok) begin
      d_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // monitor: compares every cycle against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int ch;
      bit done;
      ch = 0;
      for (int i = 0; i < 4; i++) if (dack[i]) ch = i;
      done = bus_oe && ready;
      if (bus_oe) begin
        oe_cycles++;
        if (!ready) stall_cycles++;
        mchk($countones(dack) == 1, "R1", "dack one-hot", int'(dack), 1);
        mchk(hold_ack, "R2", "bus driven without hold_ack", int'(hold_ack), 1);
        mchk(bus_addr == m_addr[ch], "R5", "bus_addr", int'(bus_addr), int'(m_addr[ch]));
        mchk({mem_wr, io_rd, mem_rd, io_wr} == (m_tom[ch] ? 4'b1100 : 4'b0011), "R3", "strobes",
             int'({mem_wr, io_rd, mem_rd, io_wr}), m_tom[ch] ? 12 : 3);
        mchk(m_arm[ch], "R7", "transfer on disarmed channel", ch, -1);
      end else begin
        mchk({dack, mem_wr, io_rd, mem_rd, io_wr, bus_addr} == '0, "R3", "idle bus outputs",
             int'({mem_wr, io_rd, mem_rd, io_wr}), 0);
        tenure = 0;
      end
      mchk(eop == (done && m_cnt[ch] == 0), "R6", "eop", int'(eop), int'(done && m_cnt[ch] == 0));
      if (prev_hold && !hold_req) mchk(!prev_oe, "R12", "hold dropped with bus driven", int'(prev_oe), 0);
      if (done) begin
        tenure++;
        nx[ch]++;
        if (eop) eop_cnt++;
        if (is_single(m_mode[ch])) mchk(tenure == 1, "R11", "transfers in tenure", tenure, 1);
        if (bus_addr == 16'h0000 && last_addr == 16'hFFFF) saw_wrap = 1;
        last_addr = bus_addr;
        if (m_cnt[ch] == 0 && m_auto[ch]) begin
          m_addr[ch] = m_badr[ch];
          m_cnt[ch]  = m_bcnt[ch];
        end else begin
          if (m_cnt[ch] == 0) m_arm[ch] = 0;
          m_addr[ch] = wrap_inc(m_addr[ch]);
          m_cnt[ch]  = m_cnt[ch] - 16'd1;
        end
      end
      if (cfg_we) begin
        m_addr[cfg_ch] = cfg_addr;  m_badr[cfg_ch] = cfg_addr;
        m_cnt[cfg_ch]  = cfg_count; m_bcnt[cfg_ch] = cfg_count;
        m_auto[cfg_ch] = cfg_auto;  m_tom[cfg_ch]  = cfg_to_mem;
        m_mode[cfg_ch] = int'(cfg_mode);
        m_arm[cfg_ch]  = 1;
      end
      prev_hold = hold_req;
      prev_oe   = bus_oe;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", m_checks + d_checks, m_fails + d_fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      d_fails++;
      d_checks++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic prog(input int ch, input int addr, input int cnt, input int mode, input bit auto_r, input bit tom);
    @(posedge clk); #1;
    cfg_we = 1; cfg_ch = 2'(ch); cfg_addr = 16'(addr); cfg_count = 16'(cnt);
    cfg_mode = 2'(mode); cfg_auto = auto_r; cfg_to_mem = tom;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic wait_oe();
    int n;
    n = 0;
    do begin @(negedge clk); n++; end while (!bus_oe && n < 2000);
    if (!bus_oe) dchk(0, "R2", "bus never granted", 0, 1);
  endtask

  task automatic wait_idle();
    int quiet, n;
    quiet = 0; n = 0;
    while (quiet < 3 && n < 5000) begin
      @(negedge clk); n++;
      if (!hold_req && !bus_oe) quiet++; else quiet = 0;
    end
    if (quiet < 3) dchk(0, "R12", "engine never idle", 1, 0);
  endtask

  task automatic drive(input logic [3:0] rq);
    @(posedge clk); #1; dreq = rq;
  endtask

  initial begin
    int b0, b1, s0, o0, e0;
    void'($urandom(32'h5eed1234));
    repeat (5) @(posedge clk);
    #1 rst_n = 1;

    // R14 reset state, requests ignored while disarmed
    @(negedge clk);
    dchk({hold_req, bus_oe, dack, eop, tc_flags} == '0, "R14", "outputs after reset",
         int'({hold_req, bus_oe, dack, eop, tc_flags}), 0);
    drive(4'hF);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      dchk(!hold_req, "R14", "hold_req with all channels disarmed", int'(hold_req), 0);
    end
    drive(4'h0);

    // R2 host withholds the bus
    host_en = 0;
    prog(0, 'h1000, 0, 0, 0, 1);
    b0 = nx[0];
    drive(4'b0001);
    repeat (10) @(negedge clk);
    dchk(hold_req && !bus_oe, "R2", "waiting for hold_ack", int'({hold_req, bus_oe}), 2);
    host_en = 1;
    drive(4'b0000);
    wait_idle();
    dchk(nx[0] - b0 == 1, "R2", "one transfer after grant", nx[0] - b0, 1);

    // R1 priority, R7 terminal count disarms
    prog(1, 'h2000, 0, 0, 0, 0);
    prog(0, 'h3000, 0, 0, 0, 1);
    drive(4'b0011);
    wait_oe();
    dchk(dack == 4'b0001, "R1", "first winner", int'(dack), 1);
    while (bus_oe) @(negedge clk);
    wait_oe();
    dchk(dack == 4'b0010, "R1", "second winner", int'(dack), 2);
    wait_idle();
    dchk(tc_flags[1:0] == 2'b11, "R7", "tc flags", int'(tc_flags), 3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      dchk(!hold_req, "R7", "request after terminal count", int'(hold_req), 0);
    end
    drive(4'b0000);

    // R9 block continues after the request drops
    prog(0, 'h4000, 4, 1, 0, 1);
    dchk(tc_flags[0] == 0, "R7", "reprogram clears flag", int'(tc_flags[0]), 0);
    b0 = nx[0];
    drive(4'b0001);
    wait_oe();
    drive(4'b0000);
    wait_idle();
    dchk(nx[0] - b0 == 5, "R9", "block transfer count", nx[0] - b0, 5);

    // R10 demand pause and resume
    prog(1, 'h5000, 9, 2, 0, 0);
    b1 = nx[1];
    drive(4'b0010);
    wait_oe();
    repeat (3) @(posedge clk);
    #1 dreq = 4'b0000;
    wait_idle();
    dchk(nx[1] - b1 == 4, "R10", "transfers before pause", nx[1] - b1, 4);
    dchk(tc_flags[1] == 0, "R10", "paused channel not finished", int'(tc_flags[1]), 0);
    drive(4'b0010);
    wait_idle();
    dchk(nx[1] - b1 == 10, "R10", "total after resume", nx[1] - b1, 10);
    dchk(tc_flags[1] == 1, "R7", "demand channel flagged", int'(tc_flags[1]), 1);
    drive(4'b0000);

    // R11 single mode with request held
    prog(2, 'h6000, 2, 0, 0, 1);
    b0 = nx[2];
    drive(4'b0100);
    wait_idle();
    dchk(nx[2] - b0 == 3, "R11", "single transfers", nx[2] - b0, 3);
    drive(4'b0000);

    // R13 wrap
    prog(2, 'hFFFE, 3, 1, 0, 0);
    b0 = nx[2];
    drive(4'b0100);
    wait_oe();
    drive(4'b0000);
    wait_idle();
    dchk(saw_wrap, "R13", "address wrapped to 0", int'(saw_wrap), 1);
    dchk(nx[2] - b0 == 4, "R13", "transfers across wrap", nx[2] - b0, 4);

    // R4 ready stretch
    prog(3, 'h7000, 1, 1, 0, 1);
    b0 = nx[3]; s0 = stall_cycles; o0 = oe_cycles;
    @(posedge clk); #1 ready = 0; dreq = 4'b1000;
    wait_oe();
    repeat (3) @(posedge clk);
    #1 ready = 1; dreq = 4'b0000;
    wait_idle();
    dchk(stall_cycles - s0 == 3, "R4", "stall cycles", stall_cycles - s0, 3);
    dchk(nx[3] - b0 == 2, "R4", "transfers with stall", nx[3] - b0, 2);
    dchk(oe_cycles - o0 == 5, "R4", "bus cycles", oe_cycles - o0, 5);

    // R8 auto-reload
    prog(3, 'h0200, 1, 1, 1, 0);
    b0 = nx[3]; e0 = eop_cnt;
    drive(4'b1000);
    wait_oe();
    drive(4'b0000);
    wait_idle();
    dchk(nx[3] - b0 == 2, "R8", "first buffer", nx[3] - b0, 2);
    dchk(tc_flags[3] == 0, "R8", "flag stays clear", int'(tc_flags[3]), 0);
    dchk(eop_cnt - e0 == 1, "R6", "one eop per buffer", eop_cnt - e0, 1);
    drive(4'b1000);
    wait_oe();
    dchk(bus_addr == 16'h0200, "R8", "reloaded address", int'(bus_addr), 'h200);
    drive(4'b0000);
    wait_idle();
    dchk(nx[3] - b0 == 4, "R8", "second buffer", nx[3] - b0, 4);
    prog(3, 'h0300, 0, 0, 0, 1);

    // random phase
    b0 = nx[0] + nx[1] + nx[2] + nx[3];
    for (int c = 0; c < 4000; c++) begin
      int pc;
      @(posedge clk); #1;
      cfg_we = 0;
      for (int i = 0; i < 4; i++) if ($urandom % 4 == 0) dreq[i] = ~dreq[i];
      ready = ($urandom % 5) != 0;
      pc = $urandom % 4;
      if (!m_arm[pc] && ($urandom % 6 == 0)) begin
        cfg_we = 1; cfg_ch = 2'(pc);
        cfg_addr = ($urandom % 4 == 0) ? 16'hFFFC : 16'($urandom);
        cfg_count = 16'($urandom % 8);
        cfg_mode = 2'($urandom % 4);
        cfg_auto = ($urandom % 6 == 0);
        cfg_to_mem = 1'($urandom);
      end
    end
    @(posedge clk); #1 cfg_we = 0; dreq = 4'b0000; ready = 1;
    wait_idle();
    dchk((nx[0] + nx[1] + nx[2] + nx[3]) - b0 > 50, "R5", "random transfers made",
         (nx[0] + nx[1] + nx[2] + nx[3]) - b0, 51);

    summary();
    $finish;
  end

endmodule